// File: doc/BRIEF.md
# 32-bit SECDED Memory Error Detection and Correction Unit

This unit sits between a processor data bus and a memory that stores 39 bits per word. On a write it computes 7 check bits over the 32-bit data word, and the two fields are stored together. On a read it captures the 39-bit word from memory and forms a syndrome. A single flipped bit is flagged, and it is corrected when it lies in the data field. Two flipped bits are flagged and left uncorrected. A word read back as all zeros or all ones is also rejected as uncorrectable. The corrected word goes into an output latch that can be frozen. Each byte of that latch has its own output enable.

A partial write is done as a read-modify-write. The selected bytes come from the processor, and the other bytes come from the last corrected read. Check bits are then computed over the merged word. A diagnostic command copies the raw input latches to the outputs. This shows whether a fault lies in the stored word or in the unit itself.

One state machine sequences all commands:
- `ST_IDLE` accepts a command and loads the input latches. Write and merge go to `ST_ENCODE`. Read goes to `ST_DECODE`. Diagnostic goes to `ST_DIAG`.
- `ST_ENCODE`, `ST_DECODE` and `ST_DIAG` each last one cycle and always return to `ST_IDLE`.

Top module: `edac32`

## Requirements
- R1: For data bit i, the check-matrix column is the i-th 7-bit value with exactly three ones, in ascending numeric order. Check bit j has column 1<<j. Check bit j is the XOR of the data bits whose column has bit j set, and bits 0 and 1 are then inverted. A write command (cmd_op 2'b00) presents the data on mem_wdata and its check bits on mem_wcheck, with mem_wvalid high for one cycle after the second rising edge following acceptance.
- R2: A read (cmd_op 2'b01) of a valid codeword gives syndrome 0, err_single low, err_double low and the data unchanged.
- R3: A single flipped data bit i raises err_single, reports the column of bit i as the syndrome, and returns the original data.
- R4: A single flipped check bit j raises err_single, reports syndrome 1<<j, and passes the data through unchanged.
- R5: Any two flipped bits in the 39-bit word raise err_double and leave err_single low. The syndrome is the XOR of the two columns, and the data bits are output as read, without correction.
- R6: An all-zeros word raises err_double with syndrome 7'h03. An all-ones word raises err_double with syndrome 7'h7F.
- R7: Decode results and a one-cycle rdata_valid pulse appear after the second rising edge following acceptance. busy is high while the unit is not idle. A command presented while busy is ignored.
- R8: While out_hold is high, the output latch keeps its value. The syndrome and flags still update.
- R9: Byte k of cpu_rdata (bits 8k+7:8k) reads zero when byte_oe[k] is low.
- R10: A merge (cmd_op 2'b10) takes byte k from cpu_wdata when cmd_byte_wen[k] is high, and from the last corrected read word otherwise. It then writes the merged word with new check bits, as in R1.
- R11: A diagnostic command (cmd_op 2'b11) loads the raw, uncorrected data input latch into the output latch (unless out_hold is high). It also loads the raw check input latch onto diag_check.
- R12: After reset, busy, mem_wvalid, rdata_valid, both flags, syndrome, cpu_rdata, mem_wdata, mem_wcheck and diag_check are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | 00 write, 01 read, 10 merge, 11 diagnostic |
| cmd_byte_wen | input | 4 | Merge byte selects, 1 = take processor byte |
| cpu_wdata | input | 32 | Processor write data |
| mem_rdata | input | 32 | Data field read from memory |
| mem_rcheck | input | 7 | Check field read from memory |
| out_hold | input | 1 | Freezes the output data latch |
| byte_oe | input | 4 | Per-byte output enables for cpu_rdata |
| busy | output | 1 | Unit is sequencing a command |
| mem_wdata | output | 32 | Data field to store |
| mem_wcheck | output | 7 | Check field to store |
| mem_wvalid | output | 1 | One-cycle pulse: store word is ready |
| cpu_rdata | output | 32 | Corrected (or diagnostic) data, byte gated |
| rdata_valid | output | 1 | One-cycle pulse: decode results ready |
| err_single | output | 1 | Single-bit error detected |
| err_double | output | 1 | Uncorrectable error detected |
| syndrome | output | 7 | Syndrome of the last decode |
| diag_check | output | 7 | Raw check latch from the last diagnostic |

## Verification
Random data words are encoded and read back in four forms: unchanged, with one data bit flipped, with one check bit flipped, and with two random bits flipped. These four forms separate the no-error path, correction in the data field, pass-through on a check-bit error, and the uncorrectable case. Each syndrome value is compared with a column table that the bench builds itself, so a wrong or swapped column is caught. Directed cases cover the all-zeros and all-ones words, a command issued while busy, a frozen output latch, partial byte enables, a merge after a corrected read, and a diagnostic readback after a corrupted read. The diagnostic case shows that the raw latch differs from the corrected output.

// File: rtl/edac32_pkg.sv
package edac32_pkg;
    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;
    localparam int CODE_W = DATA_W + CHK_W;
    localparam int BYTE_W = 8;
    localparam int NBYTES = DATA_W / BYTE_W;
    localparam logic [CHK_W-1:0] INV_MASK = CHK_W'(3);

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_MERGE = 2'd2,
        OP_DIAG  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ENCODE = 2'd1,
        ST_DECODE = 2'd2,
        ST_DIAG   = 2'd3
    } state_e;

    // Column of the parity-check matrix for code position idx.
    // Data positions take odd-weight (>=3) values in weight-then-value order,
    // check positions take unit vectors.
    function automatic logic [CHK_W-1:0] h_col(input int idx);
        logic [CHK_W-1:0] r;
        logic [CHK_W-1:0] vv;
        int n;
        r = '0;
        n = 0;
        if (idx >= DATA_W) begin
            r = CHK_W'(1) << (idx - DATA_W);
        end else begin
            for (int w = 3; w <= CHK_W; w += 2) begin
                for (int v = 0; v < (1 << CHK_W); v++) begin
                    vv = CHK_W'(v);
                    if ($countones(vv) == w) begin
                        if (n == idx) r = vv;
                        n++;
                    end
                end
            end
        end
        return r;
    endfunction

    // Data bits that feed check bit row.
    function automatic logic [DATA_W-1:0] row_mask(input int row);
        logic [DATA_W-1:0] m;
        logic [CHK_W-1:0] c;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c = h_col(i);
            m[i] = c[row];
        end
        return m;
    endfunction
endpackage

// File: rtl/edac32_parity.sv
module edac32_parity
    import edac32_pkg::*;
#(
    parameter logic [CHK_W-1:0] INV = INV_MASK
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  check_o
);
    for (genvar j = 0; j < CHK_W; j++) begin : g_row
        localparam logic [DATA_W-1:0] ROW = row_mask(j);
        assign check_o[j] = (^(data_i & ROW)) ^ INV[j];
    end
endmodule

// File: rtl/edac32_decode.sv
module edac32_decode
    import edac32_pkg::*;
#(
    parameter logic [CHK_W-1:0] INV = INV_MASK
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  check_i,
    output logic [CHK_W-1:0]  syn_o,
    output logic              single_o,
    output logic              double_o,
    output logic [DATA_W-1:0] data_o
);
    logic [CHK_W-1:0]  calc;
    logic [CODE_W-1:0] hit;

    edac32_parity #(.INV(INV)) u_par (
        .data_i  (data_i),
        .check_o (calc)
    );

    assign syn_o = calc ^ check_i;

    for (genvar p = 0; p < CODE_W; p++) begin : g_pos
        localparam logic [CHK_W-1:0] COL = h_col(p);
        assign hit[p] = (syn_o == COL);
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_fix
        assign data_o[i] = data_i[i] ^ hit[i];
    end

    assign single_o = |hit;
    assign double_o = (syn_o != '0) && !single_o;

    always_comb begin
        AST_HIT_ONEHOT: assert ($onehot0(hit)); // R3
        AST_CHECKBIT_PASS: assert (!(single_o && (hit[CODE_W-1:DATA_W] != '0)) || (data_o == data_i)); // R4
        AST_DOUBLE_NO_FIX: assert (!double_o || (data_o == data_i)); // R5
    end
endmodule

// File: rtl/edac32_fsm.sv
module edac32_fsm
    import edac32_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output logic       busy_o,
    output logic       ld_wr_o,
    output logic       ld_rd_o,
    output logic       ld_mg_o,
    output logic       enc_o,
    output logic       dec_o,
    output logic       diag_o
);
    state_e state_q, state_d;
    op_e    op;

    assign op = op_e'(cmd_op);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (op)
                        OP_WRITE, OP_MERGE: state_d = ST_ENCODE;
                        OP_READ:            state_d = ST_DECODE;
                        OP_DIAG:            state_d = ST_DIAG;
                    endcase
                end
            end
            ST_ENCODE: state_d = ST_IDLE;
            ST_DECODE: state_d = ST_IDLE;
            ST_DIAG:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o  = 1'b0;
        ld_wr_o = 1'b0;
        ld_rd_o = 1'b0;
        ld_mg_o = 1'b0;
        enc_o   = 1'b0;
        dec_o   = 1'b0;
        diag_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ld_wr_o = cmd_valid && (op == OP_WRITE);
                ld_rd_o = cmd_valid && (op == OP_READ);
                ld_mg_o = cmd_valid && (op == OP_MERGE);
            end
            ST_ENCODE: begin busy_o = 1'b1; enc_o  = 1'b1; end
            ST_DECODE: begin busy_o = 1'b1; dec_o  = 1'b1; end
            ST_DIAG:   begin busy_o = 1'b1; diag_o = 1'b1; end
        endcase
    end

    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q == ST_IDLE)); // R7
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_wr_o, ld_rd_o, ld_mg_o, enc_o, dec_o, diag_o})); // R7
endmodule

// File: rtl/edac32.sv
module edac32
    import edac32_pkg::*;
#(
    parameter logic [CHK_W-1:0] INV = INV_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [NBYTES-1:0] cmd_byte_wen,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [CHK_W-1:0]  mem_rcheck,
    input  logic              out_hold,
    input  logic [NBYTES-1:0] byte_oe,
    output logic              busy,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [CHK_W-1:0]  mem_wcheck,
    output logic              mem_wvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              rdata_valid,
    output logic              err_single,
    output logic              err_double,
    output logic [CHK_W-1:0]  syndrome,
    output logic [CHK_W-1:0]  diag_check
);
    logic ld_wr, ld_rd, ld_mg, enc, dec, diag;

    logic [DATA_W-1:0] din_q, corr_q, out_q, mwdata_q, merged, dec_data;
    logic [CHK_W-1:0]  cin_q, mwchk_q, syn_q, diag_q, enc_chk, dec_syn;
    logic              mwvalid_q, rvalid_q, sgl_q, dbl_q, dec_sgl, dec_dbl;

    edac32_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .busy_o    (busy),
        .ld_wr_o   (ld_wr),
        .ld_rd_o   (ld_rd),
        .ld_mg_o   (ld_mg),
        .enc_o     (enc),
        .dec_o     (dec),
        .diag_o    (diag)
    );

    edac32_parity #(.INV(INV)) u_enc (
        .data_i  (din_q),
        .check_o (enc_chk)
    );

    edac32_decode #(.INV(INV)) u_dec (
        .data_i   (din_q),
        .check_i  (cin_q),
        .syn_o    (dec_syn),
        .single_o (dec_sgl),
        .double_o (dec_dbl),
        .data_o   (dec_data)
    );

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign merged[k*BYTE_W +: BYTE_W] = cmd_byte_wen[k] ? cpu_wdata[k*BYTE_W +: BYTE_W]
                                                            : corr_q[k*BYTE_W +: BYTE_W];
        assign cpu_rdata[k*BYTE_W +: BYTE_W] = byte_oe[k] ? out_q[k*BYTE_W +: BYTE_W]
                                                          : {BYTE_W{1'b0}};
    end

    // Input latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_q <= '0;
            cin_q <= '0;
        end else if (ld_wr) begin
            din_q <= cpu_wdata;
        end else if (ld_mg) begin
            din_q <= merged;
        end else if (ld_rd) begin
            din_q <= mem_rdata;
            cin_q <= mem_rcheck;
        end
    end

    // Store path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mwdata_q  <= '0;
            mwchk_q   <= '0;
            mwvalid_q <= 1'b0;
        end else begin
            mwvalid_q <= enc;
            if (enc) begin
                mwdata_q <= din_q;
                mwchk_q  <= enc_chk;
            end
        end
    end

    // Decode results, output latch and diagnostic readback
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            syn_q    <= '0;
            sgl_q    <= 1'b0;
            dbl_q    <= 1'b0;
            corr_q   <= '0;
            out_q    <= '0;
            rvalid_q <= 1'b0;
            diag_q   <= '0;
        end else begin
            rvalid_q <= dec;
            if (dec) begin
                syn_q  <= dec_syn;
                sgl_q  <= dec_sgl;
                dbl_q  <= dec_dbl;
                corr_q <= dec_data;
                if (!out_hold) out_q <= dec_data;
            end
            if (diag) begin
                diag_q <= cin_q;
                if (!out_hold) out_q <= din_q;
            end
        end
    end

    assign mem_wdata   = mwdata_q;
    assign mem_wcheck  = mwchk_q;
    assign mem_wvalid  = mwvalid_q;
    assign rdata_valid = rvalid_q;
    assign err_single  = sgl_q;
    assign err_double  = dbl_q;
    assign syndrome    = syn_q;
    assign diag_check  = diag_q;

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_single && err_double)); // R5
    AST_CLEAN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (syndrome == '0) |-> (!err_single && !err_double)); // R2
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rd |=> ##1 rdata_valid); // R7
    AST_WRITE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_wr || ld_mg) |=> ##1 mem_wvalid); // R1
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid); // R7
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        out_hold |=> $stable(out_q)); // R8
    AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !mem_wvalid) |=> $stable(mem_wdata)); // R1
endmodule

// File: tb/edac32_tb_top.sv
module edac32_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [3:0]  cmd_byte_wen = 4'h0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] mem_rdata = '0;
    logic [6:0]  mem_rcheck = '0;
    logic        out_hold = 1'b0;
    logic [3:0]  byte_oe = 4'hF;
    logic        busy, mem_wvalid, rdata_valid, err_single, err_double;
    logic [31:0] mem_wdata, cpu_rdata;
    logic [6:0]  mem_wcheck, syndrome, diag_check;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    edac32 dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_byte_wen(cmd_byte_wen), .cpu_wdata(cpu_wdata), .mem_rdata(mem_rdata),
        .mem_rcheck(mem_rcheck), .out_hold(out_hold), .byte_oe(byte_oe), .busy(busy),
        .mem_wdata(mem_wdata), .mem_wcheck(mem_wcheck), .mem_wvalid(mem_wvalid),
        .cpu_rdata(cpu_rdata), .rdata_valid(rdata_valid), .err_single(err_single),
        .err_double(err_double), .syndrome(syndrome), .diag_check(diag_check)
    );

    function automatic logic [6:0] tb_col(input int idx);
        int n;
        n = 0;
        if (idx >= 32) return 7'(1 << (idx - 32));
        for (int c = 2; c < 7; c++)
            for (int b = 1; b < c; b++)
                for (int a = 0; a < b; a++) begin
                    if (n == idx) return 7'((1 << c) | (1 << b) | (1 << a));
                    n++;
                end
        return 7'h00;
    endfunction

    function automatic logic [6:0] tb_enc(input logic [31:0] d);
        logic [6:0] r;
        r = 7'b0000011;
        for (int i = 0; i < 32; i++) if (d[i]) r ^= tb_col(i);
        return r;
    endfunction

    function automatic logic [31:0] oe_mask(input logic [3:0] oe);
        logic [31:0] m;
        for (int k = 0; k < 4; k++) m[k*8 +: 8] = {8{oe[k]}};
        return m;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [31:0] wd, input logic [3:0] be,
                          input logic [31:0] rd, input logic [6:0] rc);
        @(negedge clk);
        cmd_op = op; cpu_wdata = wd; cmd_byte_wen = be; mem_rdata = rd; mem_rcheck = rc;
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic flip(input int p, inout logic [31:0] d, inout logic [6:0] c);
        if (p < 32) d[p] = ~d[p];
        else        c[p-32] = ~c[p-32];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        logic [31:0] d, rd, exp_d;
        logic [6:0]  c, rc, exp_s;
        logic [3:0]  oe;
        int kind, pa, pb;
        void'($urandom(32'd2024));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12", "busy", busy, 0);
        chk("R12", "mem_wvalid", mem_wvalid, 0);
        chk("R12", "rdata_valid", rdata_valid, 0);
        chk("R12", "flags", {err_single, err_double}, 0);
        chk("R12", "syndrome", syndrome, 0);
        chk("R12", "cpu_rdata", cpu_rdata, 0);
        chk("R12", "mem_word", {mem_wcheck, mem_wdata}, 0);
        chk("R12", "diag_check", diag_check, 0);

        // R6 gross errors
        do_cmd(2'd1, 0, 0, 32'h0, 7'h00);
        chk("R6", "zeros double", {err_single, err_double}, 2'b01);
        chk("R6", "zeros syndrome", syndrome, 7'h03);
        do_cmd(2'd1, 0, 0, 32'hFFFF_FFFF, 7'h7F);
        chk("R6", "ones double", {err_single, err_double}, 2'b01);
        chk("R6", "ones syndrome", syndrome, 7'h7F);

        // R7 command while busy is ignored
        d = 32'hCAFE_0123;
        @(negedge clk);
        cmd_op = 2'd1; mem_rdata = d; mem_rcheck = tb_enc(d); cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R7", "busy during decode", busy, 1);
        cmd_op = 2'd0; cpu_wdata = 32'h1111_1111;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R7", "rdata_valid", rdata_valid, 1);
        chk("R7", "mem_wvalid while busy cmd", mem_wvalid, 0);
        chk("R2", "clean data", cpu_rdata, d);
        @(posedge clk);
        @(negedge clk);
        chk("R7", "valid pulse ends", rdata_valid, 0);
        chk("R7", "ignored write", mem_wvalid, 0);
        chk("R7", "idle again", busy, 0);

        // R8 hold and R9 byte gating
        do_cmd(2'd1, 0, 0, 32'h1234_5678, tb_enc(32'h1234_5678));
        out_hold = 1'b1;
        d = 32'h8765_4321; c = tb_enc(d); d[7] = ~d[7];
        do_cmd(2'd1, 0, 0, d, c);
        chk("R8", "held data", cpu_rdata, 32'h1234_5678);
        chk("R8", "syndrome updates", syndrome, tb_col(7));
        out_hold = 1'b0;
        byte_oe = 4'b0101;
        #1;
        chk("R9", "gated bytes", cpu_rdata, 32'h0034_0078);
        byte_oe = 4'hF;

        // R10 merge after corrected read
        d = 32'h1122_3344; c = tb_enc(d); d[5] = ~d[5];
        do_cmd(2'd1, 0, 0, d, c);
        chk("R3", "pre-merge correct", cpu_rdata, 32'h1122_3344);
        do_cmd(2'd2, 32'hAABB_CCDD, 4'b0110, 0, 0);
        chk("R10", "merged data", mem_wdata, 32'h11BB_CC44);
        chk("R10", "merged check", mem_wcheck, tb_enc(32'h11BB_CC44));
        chk("R10", "merged valid", mem_wvalid, 1);

        // R11 diagnostic readback
        d = 32'h0F0F_A5A5; c = tb_enc(d); rd = d; rc = c;
        rd[3] = ~rd[3]; rc[2] = ~rc[2];
        do_cmd(2'd1, 0, 0, rd, rc);
        chk("R5", "data+check double", {err_single, err_double}, 2'b01);
        do_cmd(2'd3, 0, 0, 0, 0);
        chk("R11", "raw data", cpu_rdata, rd);
        chk("R11", "raw check", diag_check, rc);

        // Random sweep: R1..R5
        for (int it = 0; it < 400; it++) begin
            d = $urandom;
            oe = 4'($urandom);
            do_cmd(2'd0, d, 0, 0, 0);
            chk("R1", "write data", mem_wdata, d);
            chk("R1", "write check", mem_wcheck, tb_enc(d));
            chk("R1", "write valid", mem_wvalid, 1);
            rd = d; rc = tb_enc(d);
            kind = int'($urandom % 4);
            exp_d = d; exp_s = 7'h00;
            if (kind == 1) begin
                pa = int'($urandom % 32);
                flip(pa, rd, rc); exp_s = tb_col(pa);
            end else if (kind == 2) begin
                pa = 32 + int'($urandom % 7);
                flip(pa, rd, rc); exp_s = tb_col(pa);
            end else if (kind == 3) begin
                pa = int'($urandom % 39);
                pb = (pa + 1 + int'($urandom % 38)) % 39;
                flip(pa, rd, rc); flip(pb, rd, rc);
                exp_s = tb_col(pa) ^ tb_col(pb); exp_d = rd;
            end
            byte_oe = oe;
            do_cmd(2'd1, 0, 0, rd, rc);
            case (kind)
                0: begin
                    chk("R2", "flags", {err_single, err_double}, 2'b00);
                    chk("R2", "data", cpu_rdata, exp_d & oe_mask(oe));
                    chk("R2", "syndrome", syndrome, exp_s);
                end
                1: begin
                    chk("R3", "flags", {err_single, err_double}, 2'b10);
                    chk("R3", "data", cpu_rdata, exp_d & oe_mask(oe));
                    chk("R3", "syndrome", syndrome, exp_s);
                end
                2: begin
                    chk("R4", "flags", {err_single, err_double}, 2'b10);
                    chk("R4", "data", cpu_rdata, exp_d & oe_mask(oe));
                    chk("R4", "syndrome", syndrome, exp_s);
                end
                default: begin
                    chk("R5", "flags", {err_single, err_double}, 2'b01);
                    chk("R5", "data", cpu_rdata, exp_d & oe_mask(oe));
                    chk("R5", "syndrome", syndrome, exp_s);
                end
            endcase
            chk("R7", "rdata_valid", rdata_valid, 1);
        end
        byte_oe = 4'hF;
        report();
    end
endmodule